// File: doc/BRIEF.md
# Watchdog Timer with Halt-Mode Handling

This block is a supervisory watchdog for a small microcontroller. A 7-bit down-counter sits in a single control register next to a sticky enable bit. Once the watchdog is armed, the counter steps down on every prescaler period. Software must rewrite the counter before it falls through 40h. If it does not, the block raises a one-cycle system reset request. Software can also force a reset on purpose: it writes the enable bit together with a counter value whose bit 6 is zero.

Two configuration inputs, driven from non-volatile option storage elsewhere, change the behaviour. The first keeps the watchdog permanently armed. The second turns entry into the halt state into an immediate reset. Without the second option, halt freezes the counter and its prescaler. Only an external wake-up interrupt or a system reset ends that frozen state. After a wake-up, counting restarts only once a fixed clock delay has passed.

Top module: `cpu_watchdog`

## Requirements
- R1: After reset the register reads 7Fh (enable bit 7 = 0, counter bits 6:0 = 7Fh) and `wdg_rst_o` is low.
- R2: With the enable bit clear and the always-on option off, the counter holds its value and no reset request is raised.
- R3: A write with bit 7 = 1 sets the enable bit. A later write with bit 7 = 0 leaves it set, and the counter still takes bits 6:0 of that write.
- R4: While the watchdog is armed, the counter decrements once every PRESCALE clocks. Every register write clears the prescaler, so the first decrement lands PRESCALE clocks after the write.
- R5: An armed counter that steps from 40h to 3Fh raises `wdg_rst_o` on the clock after that step. A write of C0h therefore gives a request PRESCALE+1 clocks after the write.
- R6: A write that sets bit 7 and clears bit 6 raises `wdg_rst_o` on the clock after the write.
- R7: `wdg_rst_o` is high for exactly one clock per event. No further request follows until the block is reset.
- R8: With `opt_hw_wdg_i` high, the counter runs while the enable bit reads 0, and a timeout raises a request.
- R9: `wait_i` has no effect on counting or timing.
- R10: With `opt_halt_rst_i` high and the watchdog armed, `halt_i` raises `wdg_rst_o` on the next clock. With the watchdog disarmed, halt raises no request.
- R11: With `opt_halt_rst_i` low, halt freezes the counter and prescaler. No reset request is raised until a wake-up or a reset.
- R12: A pulse on `ext_irq_i` during halt restarts the prescaler WAKE_DELAY clocks later, and it resumes from its frozen count.
- R13: A reset during halt returns the block to its disarmed 7Fh state, and it stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Write data: bit 7 enable, bits 6:0 counter |
| rd_data_o | output | 8 | Control register read value |
| halt_i | input | 1 | CPU has entered halt |
| wait_i | input | 1 | CPU is in wait state |
| ext_irq_i | input | 1 | External wake-up interrupt |
| opt_hw_wdg_i | input | 1 | Option: watchdog always armed |
| opt_halt_rst_i | input | 1 | Option: halt forces reset |
| wdg_rst_o | output | 1 | Single-cycle system reset request |

## Verification
The case that is hardest to reach is the resumption of counting after a wake-up. The prescaler value frozen at halt entry must carry through the wake delay unchanged. The stimulus writes the register one clock before asserting halt, so the frozen prescaler phase is known exactly. It then holds halt for several prescaler periods and pulses the interrupt. After that it samples the counter on the clocks on each side of the first decrement. A second scenario starts halt and then applies reset. It confirms that the disarmed state survives afterwards.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned CNT_W = 7;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALTED = 2'd1,
    ST_WAKE   = 2'd2
  } halt_state_e;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] cnt;
  } wdg_ctrl_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned PRESCALE = 12288
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pcnt_q;

  assign tick_o = run_i && !clr_i && (pcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pcnt_q <= '0;
    else if (clr_i)            pcnt_q <= '0;
    else if (run_i) begin
      if (pcnt_q == LAST)      pcnt_q <= '0;
      else                     pcnt_q <= pcnt_q + 1'b1;
    end
  end

  p_frozen_prescaler_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/wdg_halt_ctrl.sv
module wdg_halt_ctrl
  import wdg_pkg::*;
#(
  parameter int unsigned WAKE_DELAY = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        halt_i,
  input  logic        irq_i,
  output logic        running_o,
  output halt_state_e state_o
);
  localparam int unsigned DW = (WAKE_DELAY > 1) ? $clog2(WAKE_DELAY) : 1;
  localparam logic [DW-1:0] DLAST = DW'(WAKE_DELAY - 1);

  halt_state_e   state_q, state_d;
  logic [DW-1:0] dcnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (halt_i) state_d = ST_HALTED;
      ST_HALTED: if (irq_i)  state_d = ST_WAKE;
      ST_WAKE:   if (dcnt_q == DLAST) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAKE) dcnt_q <= dcnt_q + 1'b1;
      else                    dcnt_q <= '0;
    end
  end

  assign running_o = (state_q == ST_RUN);
  assign state_o   = state_q;

  // only an interrupt leaves the frozen state
  p_halt_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALTED && !irq_i) |=> (state_q == ST_HALTED));
  p_wake_not_running_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALTED && irq_i) |=> !running_o);
endmodule

// File: rtl/wdg_ctrl_reg.sv
module wdg_ctrl_reg
  import wdg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic      tick_i,
  output wdg_ctrl_t ctrl_o
);
  wdg_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q.en  <= 1'b0;
      ctrl_q.cnt <= '1;
    end else if (wr_en_i) begin
      ctrl_q.en  <= ctrl_q.en | wr_data_i[7];  // enable is set-only
      ctrl_q.cnt <= wr_data_i[CNT_W-1:0];
    end else if (tick_i) begin
      ctrl_q.cnt <= ctrl_q.cnt - 7'd1;
    end
  end

  assign ctrl_o = ctrl_q;

  p_enable_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.en |=> ctrl_q.en);
  p_tick_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_en_i) |=> (ctrl_q.cnt == $past(ctrl_q.cnt) - 7'd1));
endmodule

// File: rtl/cpu_watchdog.sv
module cpu_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned PRESCALE   = 12288,
  parameter int unsigned WAKE_DELAY = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  input  logic       halt_i,
  input  logic       wait_i,
  input  logic       ext_irq_i,
  input  logic       opt_hw_wdg_i,
  input  logic       opt_halt_rst_i,
  output logic       wdg_rst_o
);
  wdg_ctrl_t   ctrl;
  halt_state_e hstate;
  logic        running, tick, armed, fired_q, trig, rst_q;
  logic        unused_wait;

  assign unused_wait = wait_i;  // wait state does not affect the watchdog

  assign armed = ctrl.en | opt_hw_wdg_i;

  wdg_prescaler #(.PRESCALE(PRESCALE)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_en_i),
    .run_i  (armed && running && !fired_q),
    .tick_o (tick)
  );

  wdg_halt_ctrl #(.WAKE_DELAY(WAKE_DELAY)) i_halt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .halt_i    (halt_i),
    .irq_i     (ext_irq_i),
    .running_o (running),
    .state_o   (hstate)
  );

  wdg_ctrl_reg i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick),
    .ctrl_o    (ctrl)
  );

  assign trig = armed && (!ctrl.cnt[CNT_W-1] ||
                          (running && halt_i && opt_halt_rst_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      rst_q   <= trig && !fired_q;
      fired_q <= fired_q | trig;
    end
  end

  assign wdg_rst_o = rst_q;
  assign rd_data_o = ctrl;

  p_one_cycle_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_rst_o |=> !wdg_rst_o);
  p_timeout_fires_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ctrl.cnt[CNT_W-1] && !fired_q) |=> wdg_rst_o);
  p_disarmed_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !wr_en_i) |=> $stable(ctrl.cnt));
  p_halt_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hstate != ST_RUN && !wr_en_i) |=> $stable(ctrl.cnt));
endmodule

// File: tb/test_cpu_watchdog.sv
`timescale 1ns/100ps
module test_cpu_watchdog;
  localparam int P = 8;
  localparam int D = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, halt = 1'b0, wait_s = 1'b0, irq = 1'b0;
  logic opt_hw = 1'b0, opt_hr = 1'b0;
  logic [7:0] wr_data = '0, rd;
  logic wdg_rst;
  int checks = 0, errors = 0, pulses = 0, width_err = 0;
  logic prev = 1'b0;

  always #2.5 clk = ~clk;

  cpu_watchdog #(.PRESCALE(P), .WAKE_DELAY(D)) i_cpu_watchdog (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd), .halt_i(halt), .wait_i(wait_s), .ext_irq_i(irq),
    .opt_hw_wdg_i(opt_hw), .opt_halt_rst_i(opt_hr), .wdg_rst_o(wdg_rst)
  );

  always @(negedge clk) begin
    if (wdg_rst) pulses++;
    if (wdg_rst && prev) width_err++;
    prev = wdg_rst;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(rd == 8'h7F, "R1 reset value", rd, 8'h7F);
    check(wdg_rst == 1'b0, "R1 no request", wdg_rst, 0);
  endtask

  task automatic t_disabled();
    int base;
    do_reset(); base = pulses;
    do_write(8'h40);
    step(4 * P);
    check(rd == 8'h40, "R2 counter held", rd, 8'h40);
    check(pulses == base, "R2 no request", pulses - base, 0);
  endtask

  task automatic t_sticky();
    do_reset();
    do_write(8'hFF);
    do_write(8'h7E);
    check(rd == 8'hFE, "R3 enable sticky", rd, 8'hFE);
    do_reset();
  endtask

  task automatic t_count();
    do_reset();
    wait_s = 1'b1;  // R9: wait asserted throughout
    do_write(8'hFF);
    step(P - 1);
    check(rd == 8'hFF, "R4 before first step", rd, 8'hFF);
    step(1);
    check(rd == 8'hFE, "R4 first step (R9 wait)", rd, 8'hFE);
    step(P / 2);
    do_write(8'hF0);
    step(P - 1);
    check(rd == 8'hF0, "R4 prescaler cleared by write", rd, 8'hF0);
    step(1);
    check(rd == 8'hEF, "R4 step after clear", rd, 8'hEF);
    wait_s = 1'b0;
    do_reset();
  endtask

  task automatic t_timeout();
    int base;
    do_reset(); base = pulses;
    do_write(8'hC0);
    step(P);
    check(wdg_rst == 1'b0, "R5 not yet", wdg_rst, 0);
    step(1);
    check(wdg_rst == 1'b1, "R5 timeout request", wdg_rst, 1);
    step(5 * P);
    check(pulses - base == 1, "R7 single request", pulses - base, 1);
    check(width_err == 0, "R7 one cycle wide", width_err, 0);
    do_reset();
    check(rd == 8'h7F, "R1 value after watchdog reset", rd, 8'h7F);
  endtask

  task automatic t_soft();
    do_reset();
    do_write(8'hBF);
    step(1);
    check(wdg_rst == 1'b1, "R6 software reset", wdg_rst, 1);
    do_reset();
  endtask

  task automatic t_hw();
    opt_hw = 1'b1;
    do_reset();
    do_write(8'h41);
    check(rd[7] == 1'b0, "R8 enable bit reads 0", rd[7], 0);
    step(2 * P);
    check(wdg_rst == 1'b0, "R8 not yet", wdg_rst, 0);
    step(1);
    check(wdg_rst == 1'b1, "R8 always-on timeout", wdg_rst, 1);
    opt_hw = 1'b0;
    do_reset();
  endtask

  task automatic t_halt_rst();
    int base;
    opt_hr = 1'b1;
    do_reset();
    do_write(8'hFF);
    halt = 1'b1;
    step(1);
    check(wdg_rst == 1'b1, "R10 halt reset", wdg_rst, 1);
    halt = 1'b0;
    do_reset(); base = pulses;
    halt = 1'b1;
    step(3);
    check(pulses == base, "R10 disarmed halt no reset", pulses - base, 0);
    halt = 1'b0; opt_hr = 1'b0;
    do_reset();
  endtask

  task automatic t_halt_wake();
    int base;
    do_reset(); base = pulses;
    do_write(8'hFF);
    halt = 1'b1;
    step(1);
    step(6 * P);
    check(rd == 8'hFF, "R11 counter frozen", rd, 8'hFF);
    check(pulses == base, "R11 no request in halt", pulses - base, 0);
    irq = 1'b1; halt = 1'b0;
    step(1);
    irq = 1'b0;
    step(D - 1);
    check(rd == 8'hFF, "R12 still frozen in delay", rd, 8'hFF);
    step(P - 1);
    check(rd == 8'hFF, "R12 before resumed step", rd, 8'hFF);
    step(1);
    check(rd == 8'hFE, "R12 resumed step", rd, 8'hFE);
    do_reset();
  endtask

  task automatic t_halt_reset();
    int base;
    do_reset();
    do_write(8'hFF);
    halt = 1'b1;
    step(3);
    halt = 1'b0;
    do_reset(); base = pulses;
    check(rd == 8'h7F, "R13 reset in halt", rd, 8'h7F);
    step(3 * P);
    check(rd == 8'h7F && pulses == base, "R13 stays idle", rd, 8'h7F);
  endtask

  initial begin
    step(2);
    t_reset();
    t_disabled();
    t_sticky();
    t_count();
    t_timeout();
    t_soft();
    t_hw();
    t_halt_rst();
    t_halt_wake();
    t_halt_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule